// File: doc/BRIEF.md
# Transmit FIFO Empty Interrupt Generator

This block drives the transmitter-holding-empty status flag and the matching interrupt request of a serial port with a 16-entry transmit FIFO. It watches the FIFO occupancy that the storage logic reports. It also watches the CPU write strobe to the holding register and the read strobe of the interrupt identification register. From these it decides when the port may report that it is ready for more data.

The empty indication is not always immediate. If the FIFO never held two bytes at the same time since the flag last became set, the flag waits for one character time minus the final stop bit. The wait is counted in 16x baud enables and equals (bits per frame - 1) x 16 enables. This keeps a single byte from raising a new interrupt while it is still leaving the shift register.

When the FIFO enable bit rises and transmit interrupts are enabled, the flag and the interrupt are raised at once. The interrupt has the lowest priority of the port's sources. A read of the identification register clears it only when no receive source is pending.

Top module: `uart_tx_empty_irq`

## Requirements
- R1: After reset `thre` is 1 and `tx_irq` is 0, provided both enables are held low during reset.
- R2: `thre` is 0 in the cycle after any clock edge at which `fifo_count` is non-zero.
- R3: If `fifo_count` reached 2 or more since `thre` last rose, `thre` sets at the first clock edge at which the FIFO is found empty.
- R4: Otherwise `thre` sets (`frame_bits` - 1) x 16 `baud_tick` enables after the FIFO becomes empty. `frame_bits` is held stable while this wait runs.
- R5: A byte entering the FIFO during that wait cancels it. The wait restarts from zero when the FIFO empties again.
- R6: With `fifo_en` and `tx_ie` both 1, `tx_irq` asserts one cycle after `thre` rises. `tx_irq` is never 1 while `thre` is 0.
- R7: `tx_irq` stays 0 while `tx_ie` or `fifo_en` is 0, even when `thre` rises.
- R8: Raising `tx_ie` while `thre` is 1 and the FIFO is empty asserts `tx_irq` on the next cycle.
- R9: A `thr_wr` pulse clears `tx_irq` at the next clock edge.
- R10: An `iid_rd` pulse clears `tx_irq` at the next edge only when `hi_prio_pend` is 0. With `hi_prio_pend` 1 the interrupt stays set.
- R11: A rising `fifo_en` with `tx_ie` 1 and an empty FIFO sets `thre` and the interrupt at the next edge. Any running wait is dropped.
- R12: The two-byte record clears whenever `thre` rises, so a later single-byte transfer waits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO enable bit |
| tx_ie | input | 1 | Transmit interrupt enable bit |
| fifo_count | input | 5 | Bytes in the transmit FIFO (0..16) |
| thr_wr | input | 1 | CPU write strobe to the holding register |
| iid_rd | input | 1 | Identification register read strobe |
| hi_prio_pend | input | 1 | Any receive interrupt pending (outranks this one) |
| frame_bits | input | 4 | Total bits per frame including start and stop bits |
| baud_tick | input | 1 | 16x baud clock enable |
| thre | output | 1 | Holding register empty status |
| tx_irq | output | 1 | Transmit empty interrupt request |

## Verification
The assertions check several invariants on every cycle. A busy FIFO always drops `thre`, and a two-byte history always gives the fast empty path. The interrupt never stands without `thre`, and a write or an unmasked read always clears the request. The wait counter stays below its limit. Only the bench scenarios can show that the wait lasts the right number of baud enables and that a cancelled wait restarts from zero. They also show that masking holds off the request and that the enable edge overrides a wait in progress.

// File: rtl/uart_txe_pkg.sv
package uart_txe_pkg;

   // Number of baud enables in (frame_bits - 1) oversampled bit times
   function automatic int unsigned hold_ticks(input int unsigned frame_bits,
                                              input int unsigned ovs);
      int unsigned bits;
      bits = (frame_bits > 1) ? frame_bits - 1 : 1;
      return bits * ovs;
   endfunction

   typedef enum logic [1:0] {
      THRE_SRC_NONE  = 2'd0,
      THRE_SRC_FAST  = 2'd1,
      THRE_SRC_TIMER = 2'd2,
      THRE_SRC_KICK  = 2'd3
   } thre_src_e;

endpackage

// File: rtl/txe_occupancy_track.sv
module txe_occupancy_track #(
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned MULTI_LVL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             thre_set,
   output logic             multi_seen
);

   localparam logic [CNT_W-1:0] LVL = CNT_W'(MULTI_LVL);

   logic reached;
   assign reached = (fifo_count >= LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        multi_seen <= 1'b0;
      else if (reached)  multi_seen <= 1'b1;
      else if (thre_set) multi_seen <= 1'b0;
   end

   assert_flag_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reached |=> multi_seen);

   assert_flag_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (thre_set && !reached) |=> !multi_seen);

endmodule

// File: rtl/txe_delay_timer.sv
module txe_delay_timer #(
   parameter int unsigned TW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          cancel,
   input  logic          tick,
   input  logic [TW-1:0] limit,
   output logic          done,
   output logic          busy
);

   logic [TW-1:0] cnt;
   logic          last;

   assign last = ((cnt + TW'(1)) >= limit);
   assign done = busy && tick && !cancel && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (cancel) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy && tick) begin
         if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + TW'(1);
         end
      end
   end

   assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < limit));

   assert_cancel_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !busy);

   assert_start_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cancel) |=> (busy && cnt == '0));

endmodule

// File: rtl/txe_irq_latch.sv
module txe_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic fifo_empty,
   input  logic thre,
   input  logic thre_rise,
   input  logic kick,
   input  logic thr_wr,
   input  logic iid_rd,
   input  logic hi_prio_pend,
   output logic irq
);

   logic pend;
   logic active_q;
   logic act_rise;
   logic set_req;
   logic clr_req;

   assign act_rise = active && !active_q && thre;
   assign set_req  = active && fifo_empty && (thre_rise || act_rise || kick);
   assign clr_req  = thr_wr || !fifo_empty || (iid_rd && !hi_prio_pend && irq);
   assign irq      = pend && active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         active_q <= 1'b0;
      end else begin
         active_q <= active;
         if (clr_req)      pend <= 1'b0;
         else if (set_req) pend <= 1'b1;
      end
   end

   assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !irq);

   assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd && !hi_prio_pend && irq) |=> !irq);

   assert_read_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd && hi_prio_pend && irq && !thr_wr && fifo_empty && $stable(active)) |=> irq);

endmodule

// File: rtl/uart_tx_empty_irq.sv
module uart_tx_empty_irq #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned OVS       = 16,
   parameter int unsigned FB_W      = 4,
   parameter int unsigned MULTI_LVL = 2,
   parameter bit          DELAY_EN  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fifo_en,
   input  logic                         tx_ie,
   input  logic [$clog2(DEPTH+1)-1:0]   fifo_count,
   input  logic                         thr_wr,
   input  logic                         iid_rd,
   input  logic                         hi_prio_pend,
   input  logic [FB_W-1:0]              frame_bits,
   input  logic                         baud_tick,
   output logic                         thre,
   output logic                         tx_irq
);
   import uart_txe_pkg::*;

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int unsigned TW    = FB_W + OVS_W + 1;
   localparam bit          OVS_P2 = (OVS & (OVS - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_tx_empty_irq: DEPTH must be at least 2");
   end
   if (MULTI_LVL < 2 || MULTI_LVL > DEPTH) begin : g_bad_lvl
      $error("uart_tx_empty_irq: MULTI_LVL out of range");
   end
   if (OVS < 1) begin : g_bad_ovs
      $error("uart_tx_empty_irq: OVS must be positive");
   end

   logic          fifo_empty;
   logic          empty_q;
   logic          fall_empty;
   logic          fen_q;
   logic          kick;
   logic          active;
   logic          multi_seen;
   logic          thre_q;
   logic          thre_rise;
   logic          thre_set;
   logic          tmr_start;
   logic          tmr_done;
   logic          tmr_busy;
   logic [TW-1:0] limit;
   logic [FB_W-1:0] bits_m1;
   thre_src_e     src;

   assign fifo_empty = (fifo_count == '0);
   assign fall_empty = fifo_empty && !empty_q;
   assign active     = fifo_en && tx_ie;
   assign kick       = fifo_en && !fen_q && tx_ie && fifo_empty;
   assign thre_rise  = thre && !thre_q;
   assign bits_m1    = (frame_bits > FB_W'(1)) ? frame_bits - FB_W'(1) : FB_W'(1);

   // Wait length: shift when the oversampling ratio is a power of two
   if (OVS_P2) begin : g_lim_shift
      assign limit = TW'(bits_m1) << $clog2(OVS);
   end else begin : g_lim_mul
      assign limit = TW'(bits_m1) * TW'(OVS);
   end

   always_comb begin
      src = THRE_SRC_NONE;
      if (fifo_empty) begin
         if (kick)                        src = THRE_SRC_KICK;
         else if (fall_empty && multi_seen) src = THRE_SRC_FAST;
         else if (tmr_done)               src = THRE_SRC_TIMER;
      end
   end

   assign thre_set = (src != THRE_SRC_NONE) && !thre;

   if (DELAY_EN) begin : g_delay
      assign tmr_start = fall_empty && !multi_seen && !kick;

      txe_delay_timer #(.TW(TW)) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (tmr_start),
         .cancel (!fifo_empty || kick),
         .tick   (baud_tick),
         .limit  (limit),
         .done   (tmr_done),
         .busy   (tmr_busy)
      );
   end else begin : g_nodelay
      assign tmr_start = 1'b0;
      assign tmr_busy  = 1'b0;
      assign tmr_done  = fall_empty;
   end

   txe_occupancy_track #(.CNT_W(CNT_W), .MULTI_LVL(MULTI_LVL)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_count (fifo_count),
      .thre_set   (thre_set),
      .multi_seen (multi_seen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thre    <= 1'b1;
         thre_q  <= 1'b1;
         empty_q <= 1'b1;
         fen_q   <= 1'b0;
      end else begin
         thre_q  <= thre;
         empty_q <= fifo_empty;
         fen_q   <= fifo_en;
         if (!fifo_empty)                thre <= 1'b0;
         else if (src != THRE_SRC_NONE)  thre <= 1'b1;
      end
   end

   txe_irq_latch u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (active),
      .fifo_empty   (fifo_empty),
      .thre         (thre),
      .thre_rise    (thre_rise),
      .kick         (kick),
      .thr_wr       (thr_wr),
      .iid_rd       (iid_rd),
      .hi_prio_pend (hi_prio_pend),
      .irq          (tx_irq)
   );

   assert_busy_clears_thre_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count != '0) |=> !thre);

   assert_fast_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_empty && multi_seen) |=> thre);

   assert_irq_needs_thre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> thre);

   assert_kick_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (thre && tx_irq));

   assert_timer_idle_when_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      thre |-> !tmr_busy);

endmodule

// File: tb/uart_tx_empty_irq_tb.sv
module uart_tx_empty_irq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0;
   logic       tx_ie = 1'b0;
   logic [4:0] fifo_count = '0;
   logic       thr_wr = 1'b0;
   logic       iid_rd = 1'b0;
   logic       hi_prio_pend = 1'b0;
   logic [3:0] frame_bits = 4'd10;
   logic       baud_tick;
   logic       thre;
   logic       tx_irq;

   logic       slow_tick = 1'b0;
   logic       tick_ph = 1'b0;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;

   always @(negedge clk) tick_ph <= ~tick_ph;
   assign baud_tick = slow_tick ? tick_ph : 1'b1;

   uart_tx_empty_irq u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_ie(tx_ie),
      .fifo_count(fifo_count), .thr_wr(thr_wr), .iid_rd(iid_rd),
      .hi_prio_pend(hi_prio_pend), .frame_bits(frame_bits),
      .baud_tick(baud_tick), .thre(thre), .tx_irq(tx_irq)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // load one byte with a write strobe, then drain it
   task automatic one_byte();
      fifo_count = 5'd1; thr_wr = 1'b1; step(1);
      thr_wr = 1'b0; fifo_count = 5'd0;
   endtask

   task automatic t_reset();
      step(2);
      chk("R1 thre", thre, 1'b1);
      chk("R1 irq", tx_irq, 1'b0);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic t_kick();
      fifo_en = 1'b1; tx_ie = 1'b1;
      step(1);
      chk("R11 thre", thre, 1'b1);
      chk("R11 irq", tx_irq, 1'b1);
   endtask

   task automatic t_write_and_delay();
      fifo_count = 5'd1; thr_wr = 1'b1; step(1);
      thr_wr = 1'b0;
      chk("R9 irq cleared", tx_irq, 1'b0);
      chk("R2 thre low", thre, 1'b0);
      fifo_count = 5'd0;
      step(100);
      chk("R4 thre waiting", thre, 1'b0);
      chk("R6 irq waiting", tx_irq, 1'b0);
      step(50);
      chk("R4 thre after wait", thre, 1'b1);
      chk("R6 irq after wait", tx_irq, 1'b1);
   endtask

   task automatic t_iid_read();
      iid_rd = 1'b1; hi_prio_pend = 1'b1; step(1);
      iid_rd = 1'b0; step(1);
      chk("R10 read blocked", tx_irq, 1'b1);
      iid_rd = 1'b1; hi_prio_pend = 1'b0; step(1);
      iid_rd = 1'b0; step(1);
      chk("R10 read clears", tx_irq, 1'b0);
   endtask

   task automatic t_multi();
      fifo_count = 5'd1; thr_wr = 1'b1; step(1);
      fifo_count = 5'd2; step(1);
      thr_wr = 1'b0; fifo_count = 5'd1; step(1);
      fifo_count = 5'd0; step(1);
      chk("R3 thre fast", thre, 1'b1);
      step(1);
      chk("R6 irq fast", tx_irq, 1'b1);
   endtask

   task automatic t_rearm();
      one_byte();
      step(5);
      chk("R12 delay again", thre, 1'b0);
      step(145);
      chk("R12 thre later", thre, 1'b1);
   endtask

   task automatic t_cancel();
      one_byte();
      step(50);
      one_byte();
      step(100);
      chk("R5 restart", thre, 1'b0);
      step(50);
      chk("R5 thre after restart", thre, 1'b1);
   endtask

   task automatic t_mask();
      tx_ie = 1'b0;
      fifo_count = 5'd1; thr_wr = 1'b1; step(1);
      fifo_count = 5'd2; step(1);
      thr_wr = 1'b0; fifo_count = 5'd0; step(3);
      chk("R7 thre set", thre, 1'b1);
      chk("R7 irq masked", tx_irq, 1'b0);
      tx_ie = 1'b1; step(1);
      chk("R8 irq on enable", tx_irq, 1'b1);
   endtask

   task automatic t_kick_in_wait();
      one_byte();
      step(10);
      fifo_en = 1'b0; step(2);
      chk("R11 wait running", thre, 1'b0);
      fifo_en = 1'b1; step(1);
      chk("R11 thre forced", thre, 1'b1);
      chk("R11 irq forced", tx_irq, 1'b1);
   endtask

   task automatic t_slow_tick();
      frame_bits = 4'd7; slow_tick = 1'b1;
      one_byte();
      step(180);
      chk("R4 slow waiting", thre, 1'b0);
      step(30);
      chk("R4 slow done", thre, 1'b1);
      slow_tick = 1'b0; frame_bits = 4'd10;
   endtask

   initial begin
      t_reset();
      t_kick();
      t_write_and_delay();
      t_iid_read();
      t_multi();
      t_rearm();
      t_cancel();
      t_mask();
      t_kick_in_wait();
      t_slow_tick();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule